// File: doc/BRIEF.md
# Scoreboarded In-Order Issue Pipeline

This block executes a short program of three-register arithmetic instructions through four phases: fetch, decode, execute and writeback. Execute contains one adder and one multiplier. Neither unit is pipelined, and the two units have different latencies. Decode keeps a scoreboard that records which registers have a result still on the way. It sends the oldest instruction to its unit only when three things hold: the unit is free, both source operands can be obtained, and no earlier instruction still has to write the same destination. While that instruction waits, fetch and decode stall behind it.

A parameter chooses when a dependent instruction may start. Without forwarding, the consumer reads its operand from the register file in the producer's writeback cycle and starts execute one cycle later. With forwarding, the consumer takes the result from the producing unit during that unit's last execute cycle and starts execute in the following cycle.

The program is written into an instruction store through a write port while the block is held in reset. The block starts when `run` is raised. Two counters report progress: one counts retired instructions and one counts elapsed run cycles. A done flag marks the retirement of the last instruction, and from then on the cycle count stays fixed. Any register can be read at any time through a debug read port.

Top module: `scoreboard_pipe`

## Requirements
- R1: During reset and right after it, `retired` and `cycles` read 0, `done` reads 0, and register i holds the value i.
- R2: An instruction word is split as follows: bits [15:12] are the opcode, [11:8] the destination, [7:4] source A and [3:0] source B. Opcode 4'h3 selects multiply and every other opcode selects add. The destination receives the low 16 bits of the sum or product.
- R3: Fetch, decode and writeback each take one cycle. An add spends 4 cycles in execute and a multiply spends 6. A lone ADD therefore completes in 7 cycles and a lone MUL in 9.
- R4: A unit accepts no new operation while one is in progress. A second operation of the same type starts execute in the cycle after the previous operation's last execute cycle.
- R5: With FORWARD=0, a consumer starts execute in the cycle after its producer's writeback cycle. The register file writes before decode reads in the same cycle.
- R6: With FORWARD=1, a consumer starts execute in the cycle after its producer's last execute cycle, and it uses the forwarded value.
- R7: Instructions issue strictly in program order. An instruction whose sources are ready still waits behind an older stalled instruction. An instruction for the other unit may run while an earlier one is still executing.
- R8: An instruction whose destination is still pending does not issue until the earlier writer reaches writeback. The later value is therefore the one left in the register.
- R9: `retired` counts instructions that have completed writeback. `done` rises when `retired` reaches `prog_len`. `cycles` counts the cycles with `run` high and stops changing once `done` is set.
- R10: While `run` is low, no instruction is fetched, `cycles` does not advance and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Enables fetch and cycle counting |
| prog_len | input | 5 | Number of instructions in the program |
| rom_we | input | 1 | Instruction store write enable |
| rom_waddr | input | 4 | Instruction store write address |
| rom_wdata | input | 16 | Instruction word to write |
| reg_sel | input | 4 | Register index for the debug read |
| reg_value | output | 16 | Contents of the selected register |
| retired | output | 5 | Count of retired instructions |
| cycles | output | 32 | Count of run cycles until done |
| done | output | 1 | Last instruction has retired |

## Verification
A wrong scoreboard bit or a wrong unit busy count changes when an instruction issues. That error appears in the frozen `cycles` value as soon as `done` rises, which is within a few dozen cycles for the short programs used. An operand taken from the wrong source, or a write that lands out of order, leaves a wrong value in a destination register, and the debug read port exposes it once the run ends. Each program runs on a forwarding instance and on a non-forwarding instance side by side, so a mistake in either operand path shows up as a difference in that instance's cycle total.

// File: rtl/sbp_pkg.sv
// Package: shared constants for the scoreboarded pipeline.
// Assumes 16-bit instruction words and 16 architectural registers.
package sbp_pkg;
    localparam int INSTR_W  = 16;
    localparam int RAW      = 4;
    localparam int NREG     = 1 << RAW;
    localparam int NU       = 2;
    localparam int UNIT_ADD = 0;
    localparam int UNIT_MUL = 1;
    localparam logic [3:0] OPC_MUL = 4'h3;
endpackage

// File: rtl/sbp_regfile.sv
// Register file with one write port per functional unit and several read ports.
// Every read port bypasses a write in the same cycle, so a reader in the writer's
// writeback cycle sees the new value. Register i resets to the value i.
// Assumes the write ports never target the same register in one cycle.
module sbp_regfile
    import sbp_pkg::*;
#(
    parameter int DW  = 16,
    parameter int NW  = 2,
    parameter int NRD = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NW-1:0]            we,
    input  logic [NW-1:0][RAW-1:0]   waddr,
    input  logic [NW-1:0][DW-1:0]    wdata,
    input  logic [NRD-1:0][RAW-1:0]  raddr,
    output logic [NRD-1:0][DW-1:0]   rdata
);
    logic [DW-1:0] regs [NREG];

    // Purpose: reset every register to its own index, otherwise apply the writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= DW'(i);
        end else begin
            for (int w = 0; w < NW; w++)
                if (we[w]) regs[waddr[w]] <= wdata[w];
        end
    end

    // Purpose: read each port, taking a same-cycle write in preference to the stored value.
    always_comb begin
        for (int r = 0; r < NRD; r++) begin
            rdata[r] = regs[raddr[r]];
            for (int w = 0; w < NW; w++)
                if (we[w] && waddr[w] == raddr[r]) rdata[r] = wdata[w];
        end
    end
endmodule

// File: rtl/sbp_exec_unit.sv
// Functional unit that is not pipelined and has a fixed latency of LAT cycles.
// The result is computed when the operation is accepted and held until the unit
// hands it to its own one-cycle writeback register. During the unit's last execute
// cycle (fin_o) the result is offered for forwarding. A new operation may be
// accepted in that last cycle, so back-to-back operations leave no gap.
module sbp_exec_unit
    import sbp_pkg::*;
#(
    parameter int DW     = 16,
    parameter int LAT    = 4,
    parameter bit IS_MUL = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_i,
    input  logic [RAW-1:0]  dst_i,
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    output logic            free_o,
    output logic            fin_o,
    output logic [RAW-1:0]  fin_dst_o,
    output logic [DW-1:0]   fin_val_o,
    output logic            wb_valid_o,
    output logic [RAW-1:0]  wb_dst_o,
    output logic [DW-1:0]   wb_val_o
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0]  cnt;
    logic [RAW-1:0] dst_q;
    logic [DW-1:0]  res_q;
    logic [DW-1:0]  op_res;

    generate
        if (IS_MUL) begin : g_mul
            assign op_res = a_i * b_i;
        end else begin : g_add
            assign op_res = a_i + b_i;
        end
    endgenerate

    assign free_o    = (cnt <= CW'(1));
    assign fin_o     = (cnt == CW'(1));
    assign fin_dst_o = dst_q;
    assign fin_val_o = res_q;

    // Purpose: count down the execute cycles and move the finished result into writeback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            dst_q      <= '0;
            res_q      <= '0;
            wb_valid_o <= 1'b0;
            wb_dst_o   <= '0;
            wb_val_o   <= '0;
        end else begin
            wb_valid_o <= (cnt == CW'(1));
            wb_dst_o   <= dst_q;
            wb_val_o   <= res_q;
            if (issue_i) begin
                cnt   <= CW'(LAT);
                dst_q <= dst_i;
                res_q <= op_res;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R4: decode never hands an operation to a unit that is still busy.
    assert_issue_when_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |-> (cnt <= CW'(1)));
endmodule

// File: rtl/sbp_issue.sv
// Fetch and decode with the scoreboard. Fetch reads the instruction store into a
// single decode register. Decode issues the instruction in that register when its
// unit is free, when each source is not pending or can be obtained (same-cycle
// writeback through the register file, or the producing unit's last execute
// cycle when FORWARD is set), and when its destination is not pending. When the
// decode register is held, fetch stops.
module sbp_issue
    import sbp_pkg::*;
#(
    parameter int DW        = 16,
    parameter int ROM_DEPTH = 16,
    parameter int RA        = 4,
    parameter int PW        = 5,
    parameter bit FORWARD   = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_i,
    input  logic [PW-1:0]           prog_len_i,
    output logic [RA-1:0]           rom_addr_o,
    input  logic [INSTR_W-1:0]      rom_data_i,
    input  logic [NU-1:0]           free_i,
    input  logic [NU-1:0]           fin_i,
    input  logic [NU-1:0][RAW-1:0]  fin_dst_i,
    input  logic [NU-1:0][DW-1:0]   fin_val_i,
    input  logic [NU-1:0]           wb_valid_i,
    input  logic [NU-1:0][RAW-1:0]  wb_dst_i,
    output logic [1:0][RAW-1:0]     rf_addr_o,
    input  logic [1:0][DW-1:0]      rf_data_i,
    output logic [NU-1:0]           issue_o,
    output logic [RAW-1:0]          iss_dst_o,
    output logic [DW-1:0]           iss_a_o,
    output logic [DW-1:0]           iss_b_o
);
    logic [PW-1:0]      pc;
    logic               dec_valid;
    logic [3:0]         dec_opc;
    logic [RAW-1:0]     dec_dst, dec_sa, dec_sb;
    logic               dec_mul;
    logic [NREG-1:0]    pend, pend_nxt;
    logic               a_rdy, b_rdy, d_ok, go, fetch_en;

    assign dec_mul    = (dec_opc == OPC_MUL);
    assign rom_addr_o = pc[RA-1:0];
    assign rf_addr_o  = {dec_sb, dec_sa};
    assign iss_dst_o  = dec_dst;

    // Purpose: decide whether each source can be obtained and which value it takes.
    always_comb begin
        a_rdy   = !pend[dec_sa];
        b_rdy   = !pend[dec_sb];
        d_ok    = !pend[dec_dst];
        iss_a_o = rf_data_i[0];
        iss_b_o = rf_data_i[1];
        for (int u = 0; u < NU; u++) begin
            if (wb_valid_i[u] && wb_dst_i[u] == dec_sa)  a_rdy = 1'b1;
            if (wb_valid_i[u] && wb_dst_i[u] == dec_sb)  b_rdy = 1'b1;
            if (wb_valid_i[u] && wb_dst_i[u] == dec_dst) d_ok  = 1'b1;
            if (FORWARD && fin_i[u] && fin_dst_i[u] == dec_sa) begin
                a_rdy   = 1'b1;
                iss_a_o = fin_val_i[u];
            end
            if (FORWARD && fin_i[u] && fin_dst_i[u] == dec_sb) begin
                b_rdy   = 1'b1;
                iss_b_o = fin_val_i[u];
            end
        end
    end

    assign go = dec_valid && a_rdy && b_rdy && d_ok && free_i[dec_mul];

    // Purpose: route the issue strobe to the unit that the opcode selects.
    always_comb begin
        for (int u = 0; u < NU; u++)
            issue_o[u] = go && (dec_mul == (u == UNIT_MUL));
    end

    assign fetch_en = run_i && (pc < prog_len_i) && (pc < PW'(ROM_DEPTH))
                      && (!dec_valid || go);

    // Purpose: clear bits whose writer is in writeback, then mark the new destination.
    always_comb begin
        pend_nxt = pend;
        for (int u = 0; u < NU; u++)
            if (wb_valid_i[u]) pend_nxt[wb_dst_i[u]] = 1'b0;
        if (go) pend_nxt[dec_dst] = 1'b1;
    end

    // Purpose: hold the scoreboard bits.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend_nxt;
    end

    // Purpose: advance the fetch address and load or drain the decode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc        <= '0;
            dec_valid <= 1'b0;
            dec_opc   <= '0;
            dec_dst   <= '0;
            dec_sa    <= '0;
            dec_sb    <= '0;
        end else if (fetch_en) begin
            pc        <= pc + 1'b1;
            dec_valid <= 1'b1;
            {dec_opc, dec_dst, dec_sa, dec_sb} <= rom_data_i;
        end else if (go) begin
            dec_valid <= 1'b0;
        end
    end

    // R10: while run is low the fetch address does not move.
    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(pc));
endmodule

// File: rtl/scoreboard_pipe.sv
// Top of the scoreboarded in-order pipeline. It holds the instruction store, the
// fetch/decode/scoreboard stage, one adder and one multiplier, the register file,
// and the retire and cycle counters. The instruction store is written through its
// write port, normally while rst_n is low. Cycles are counted only while run is
// high, and the count stops when done rises.
module scoreboard_pipe
    import sbp_pkg::*;
#(
    parameter int DW        = 16,
    parameter int ROM_DEPTH = 16,
    parameter int ADD_LAT   = 4,
    parameter int MUL_LAT   = 6,
    parameter bit FORWARD   = 1'b1,
    parameter int CYC_W     = 32
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          run,
    input  logic [$clog2(ROM_DEPTH+1)-1:0]                prog_len,
    input  logic                                          rom_we,
    input  logic [((ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1)-1:0] rom_waddr,
    input  logic [INSTR_W-1:0]                            rom_wdata,
    input  logic [RAW-1:0]                                reg_sel,
    output logic [DW-1:0]                                 reg_value,
    output logic [$clog2(ROM_DEPTH+1)-1:0]                retired,
    output logic [CYC_W-1:0]                              cycles,
    output logic                                          done
);
    localparam int RA = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1;
    localparam int PW = $clog2(ROM_DEPTH + 1);

    logic [INSTR_W-1:0]      rom [ROM_DEPTH];
    logic [RA-1:0]           rom_addr;
    logic [INSTR_W-1:0]      rom_data;
    logic [NU-1:0]           free, fin, issue, wb_valid;
    logic [NU-1:0][RAW-1:0]  fin_dst, wb_dst;
    logic [NU-1:0][DW-1:0]   fin_val, wb_val;
    logic [1:0][RAW-1:0]     rf_addr;
    logic [1:0][DW-1:0]      rf_data;
    logic [RAW-1:0]          iss_dst;
    logic [DW-1:0]           iss_a, iss_b;
    logic [2:0][RAW-1:0]     rd_addr;
    logic [2:0][DW-1:0]      rd_data;
    logic [PW-1:0]           ret_inc, retired_nxt;

    // Purpose: write the instruction store from the load port.
    always_ff @(posedge clk) begin
        if (rom_we) rom[rom_waddr] <= rom_wdata;
    end
    assign rom_data = rom[rom_addr];

    sbp_issue #(
        .DW(DW), .ROM_DEPTH(ROM_DEPTH), .RA(RA), .PW(PW), .FORWARD(FORWARD)
    ) u_issue (
        .clk(clk), .rst_n(rst_n), .run_i(run), .prog_len_i(prog_len),
        .rom_addr_o(rom_addr), .rom_data_i(rom_data),
        .free_i(free), .fin_i(fin), .fin_dst_i(fin_dst), .fin_val_i(fin_val),
        .wb_valid_i(wb_valid), .wb_dst_i(wb_dst),
        .rf_addr_o(rf_addr), .rf_data_i(rf_data),
        .issue_o(issue), .iss_dst_o(iss_dst), .iss_a_o(iss_a), .iss_b_o(iss_b)
    );

    generate
        for (genvar gu = 0; gu < NU; gu++) begin : g_unit
            sbp_exec_unit #(
                .DW(DW),
                .LAT((gu == UNIT_MUL) ? MUL_LAT : ADD_LAT),
                .IS_MUL(gu == UNIT_MUL)
            ) u_unit (
                .clk(clk), .rst_n(rst_n), .issue_i(issue[gu]),
                .dst_i(iss_dst), .a_i(iss_a), .b_i(iss_b),
                .free_o(free[gu]), .fin_o(fin[gu]),
                .fin_dst_o(fin_dst[gu]), .fin_val_o(fin_val[gu]),
                .wb_valid_o(wb_valid[gu]), .wb_dst_o(wb_dst[gu]), .wb_val_o(wb_val[gu])
            );
        end
    endgenerate

    assign rd_addr   = {reg_sel, rf_addr[1], rf_addr[0]};
    assign rf_data   = {rd_data[1], rd_data[0]};
    assign reg_value = rd_data[2];

    sbp_regfile #(.DW(DW), .NW(NU), .NRD(3)) u_regfile (
        .clk(clk), .rst_n(rst_n), .we(wb_valid), .waddr(wb_dst), .wdata(wb_val),
        .raddr(rd_addr), .rdata(rd_data)
    );

    // Purpose: count how many writebacks finish this cycle.
    always_comb begin
        ret_inc = '0;
        for (int u = 0; u < NU; u++) ret_inc = ret_inc + PW'(wb_valid[u]);
    end
    assign retired_nxt = retired + ret_inc;

    // Purpose: update the retire count, the run-cycle count and the done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retired <= '0;
            cycles  <= '0;
            done    <= 1'b0;
        end else begin
            retired <= retired_nxt;
            if (run && !done) cycles <= cycles + 1'b1;
            if (prog_len != '0 && retired_nxt == prog_len) done <= 1'b1;
        end
    end

    // R8: the two units never write the same register in one cycle.
    assert_no_dual_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid[UNIT_ADD] && wb_valid[UNIT_MUL]) |-> (wb_dst[UNIT_ADD] != wb_dst[UNIT_MUL]));

    // R9: once done is set the cycle count stays where it is.
    assert_cycles_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(cycles));
endmodule

// File: tb/scoreboard_pipe_bench.sv
`timescale 1ns/1ps
module scoreboard_pipe_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [4:0]  prog_len = '0;
    logic        rom_we = 1'b0;
    logic [3:0]  rom_waddr = '0;
    logic [15:0] rom_wdata = '0;
    logic [3:0]  reg_sel = '0;
    logic [15:0] val_f, val_n;
    logic [4:0]  ret_f, ret_n;
    logic [31:0] cyc_f, cyc_n;
    logic        done_f, done_n;
    logic [15:0] prog [16];
    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    scoreboard_pipe #(.FORWARD(1'b1)) u_scoreboard_pipe (
        .clk(clk), .rst_n(rst_n), .run(run), .prog_len(prog_len), .rom_we(rom_we),
        .rom_waddr(rom_waddr), .rom_wdata(rom_wdata), .reg_sel(reg_sel),
        .reg_value(val_f), .retired(ret_f), .cycles(cyc_f), .done(done_f));

    scoreboard_pipe #(.FORWARD(1'b0)) u_scoreboard_pipe_nofwd (
        .clk(clk), .rst_n(rst_n), .run(run), .prog_len(prog_len), .rom_we(rom_we),
        .rom_waddr(rom_waddr), .rom_wdata(rom_wdata), .reg_sel(reg_sel),
        .reg_value(val_n), .retired(ret_n), .cycles(cyc_n), .done(done_n));

    function automatic logic [15:0] enc(input bit mul, input int d, input int a, input int b);
        return {(mul ? 4'h3 : 4'h1), 4'(d), 4'(a), 4'(b)};
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_reg(input string req, input int r, input int exp);
        reg_sel = 4'(r);
        #1;
        chk(req, $sformatf("fwd R%0d", r), val_f, exp);
        chk(req, $sformatf("nofwd R%0d", r), val_n, exp);
    endtask

    // Hold reset, write the program and set its length; rst_n stays low on return.
    task automatic load(input int n);
        rst_n = 1'b0;
        run   = 1'b0;
        for (int i = 0; i < n; i++) begin
            rom_we = 1'b1; rom_waddr = 4'(i); rom_wdata = prog[i];
            @(negedge clk);
        end
        rom_we   = 1'b0;
        prog_len = 5'(n);
        @(negedge clk);
    endtask

    // Release reset, run to completion, then idle a few cycles to see the freeze.
    task automatic go(input string req);
        rst_n = 1'b1;
        run   = 1'b1;
        for (int k = 0; k < 400 && !(done_f && done_n); k++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(req, "fwd done", done_f, 1);
        chk(req, "nofwd done", done_n, 1);
    endtask

    task automatic t_program_sequence();
        prog[0] = enc(1, 3, 1, 2);
        prog[1] = enc(0, 5, 4, 3);
        prog[2] = enc(0, 6, 4, 1);
        prog[3] = enc(1, 7, 8, 9);
        prog[4] = enc(0, 4, 3, 7);
        prog[5] = enc(1, 10, 5, 6);
        load(6);
        // R1: reset state
        chk("R1", "fwd retired", ret_f, 0);
        chk("R1", "fwd cycles", cyc_f, 0);
        chk("R1", "nofwd done", done_n, 0);
        chk_reg("R1", 7, 7);
        chk_reg("R1", 15, 15);
        // R10: out of reset with run low, nothing advances
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R10", "fwd cycles", cyc_f, 0);
        chk("R10", "nofwd retired", ret_n, 0);
        chk_reg("R10", 3, 3);
        go("R9");
        chk("R6", "fwd cycles", cyc_f, 27);
        chk("R5", "nofwd cycles", cyc_n, 29);
        chk("R9", "fwd retired", ret_f, 6);
        chk("R9", "nofwd retired", ret_n, 6);
        chk_reg("R2", 3, 2);
        chk_reg("R2", 5, 6);
        chk_reg("R7", 6, 5);
        chk_reg("R2", 7, 72);
        chk_reg("R7", 4, 74);
        chk_reg("R2", 10, 30);
    endtask

    task automatic t_single_latency();
        prog[0] = enc(0, 1, 2, 3);
        load(1);
        go("R3");
        chk("R3", "fwd lone add cycles", cyc_f, 7);
        chk("R3", "nofwd lone add cycles", cyc_n, 7);
        chk_reg("R2", 1, 5);
        prog[0] = enc(1, 1, 2, 3);
        load(1);
        go("R3");
        chk("R3", "fwd lone mul cycles", cyc_f, 9);
        chk("R3", "nofwd lone mul cycles", cyc_n, 9);
        chk_reg("R2", 1, 6);
    endtask

    task automatic t_unit_busy();
        prog[0] = enc(0, 1, 2, 3);
        prog[1] = enc(0, 4, 5, 6);
        load(2);
        go("R4");
        chk("R4", "fwd two adds cycles", cyc_f, 11);
        chk("R4", "nofwd two adds cycles", cyc_n, 11);
        chk_reg("R4", 1, 5);
        chk_reg("R4", 4, 11);
    endtask

    task automatic t_other_unit();
        prog[0] = enc(1, 1, 2, 3);
        prog[1] = enc(0, 4, 5, 6);
        load(2);
        go("R7");
        chk("R7", "fwd mul then add cycles", cyc_f, 9);
        chk("R7", "nofwd mul then add cycles", cyc_n, 9);
        chk("R9", "fwd retired", ret_f, 2);
        chk_reg("R7", 1, 6);
        chk_reg("R7", 4, 11);
    endtask

    task automatic t_same_dest();
        prog[0] = enc(1, 1, 2, 3);
        prog[1] = enc(0, 1, 4, 5);
        load(2);
        go("R8");
        chk("R8", "fwd cycles", cyc_f, 14);
        chk("R8", "nofwd cycles", cyc_n, 14);
        chk_reg("R8", 1, 9);
    endtask

    task automatic t_both_sources();
        prog[0] = enc(1, 1, 2, 3);
        prog[1] = enc(0, 4, 1, 1);
        load(2);
        go("R6");
        chk("R6", "fwd cycles", cyc_f, 13);
        chk("R5", "nofwd cycles", cyc_n, 14);
        chk_reg("R6", 4, 12);
    endtask

    task automatic t_truncation();
        prog[0] = enc(1, 1, 15, 15);
        prog[1] = enc(1, 2, 1, 1);
        prog[2] = enc(1, 3, 2, 15);
        load(3);
        go("R2");
        chk("R6", "fwd mul chain cycles", cyc_f, 21);
        chk("R5", "nofwd mul chain cycles", cyc_n, 23);
        chk_reg("R2", 1, 225);
        chk_reg("R2", 2, 50625);
        chk_reg("R2", 3, 38479);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_program_sequence();
        t_single_latency();
        t_unit_busy();
        t_other_unit();
        t_same_dest();
        t_both_sources();
        t_truncation();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule